// File: doc/BRIEF.md
# Interrupt vector ring writer

The block takes interrupt events from sources inside the chip and stores each one as a 16-byte vector in a circular buffer in memory, which software drains. An event carries a source id, source data, a ring id, a VM id and a PASID. The block turns it into four 32-bit memory writes at the ring base plus the current write pointer. It then moves the write pointer on by 16 bytes, wrapping at the ring's power-of-two size. Both pointers count bytes. Software reports how far it has read by writing the read pointer back through the register port.

When a new vector would land on the read pointer, an optional check raises a sticky overflow flag. The vector is still written and the pointer still advances. The flag is reported in bit 0 of the write-pointer value, and software clears it through a self-clearing control bit. The write-pointer value can also be mirrored to a programmable 40-bit memory address after every vector. A one-cycle interrupt pulse marks each finished vector. It can optionally be raised again when software writes a read pointer that leaves entries still pending.

Register port: reg_wr writes reg_wdata to reg_addr in the cycle it is high. reg_rdata shows the register at reg_addr with no delay. Addresses:
- 0: control
  - bit 0: ring enable
  - bit 1: interrupt enable
  - bit 2: overflow-check enable
  - bit 3: writeback enable
  - bit 4: rearm-on-read-pointer
  - bit 5: overflow clear (write-only, reads 0)
  - bits [12:8]: ring size as log2 of the length in 32-bit words
- 1: ring base, holding bits [39:8] of the byte address
- 2: read pointer
- 3: write pointer, with the overflow flag in bit 0
- 4: writeback address bits [31:0]
- 5: writeback address bits [39:32], in bits [7:0]

Top module: `ivring_writer`

## Requirements
- R1: After reset, every register reads as 0, and ev_ready, mem_valid, irq, pending and busy are all 0.
- R2: An accepted event produces four word writes at {base,8'h00} + wptr + 0, 4, 8 and 12, in that order:
  - word 0: {24'h0, src};
  - word 1: {4'h0, data};
  - word 2: {pasid, vm, ring};
  - word 3: 0.
- R3: Once a vector is written, the write pointer becomes (wptr + 16) & mask. The mask is 2^(size+2) − 1, and the size is clamped to MAX_LOG2W. The pointers are stored 16-byte aligned, so write-pointer bits [3:1] always read 0.
- R4: pending is 1 exactly when the ring is enabled and the read pointer differs from the write pointer.
- R5: With overflow check enabled, a vector for which (wptr + 16) & mask equals the read pointer sets the sticky flag, which reads in bit 0 of register 3. The vector is still written and the pointer still advances. With the check disabled, the flag is not set.
- R6: Writing control with bit 5 set clears the overflow flag, and bit 5 reads back as 0.
- R7: With writeback enabled, a fifth write follows each vector. It goes to the address {reg5[7:0], reg4} and carries the updated write-pointer value, including the overflow bit.
- R8: While the ring is disabled, ev_ready is 0 and no memory write starts. A write to register 3 takes effect only while the ring is disabled.
- R9: With interrupt enable set, irq pulses high for one cycle after the last memory write of each vector. With it clear, there is no pulse.
- R10: With rearm and interrupt enable both set, a read-pointer write whose masked value differs from the write pointer pulses irq in the next cycle. An equal value, or rearm clear, gives no pulse.
- R11: busy is high from the acceptance of an event until its last memory write is accepted. While mem_ready is low, mem_valid, mem_addr and mem_wdata hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken |
| ev_src | input | 8 | Source id |
| ev_data | input | 28 | Source data |
| ev_ring | input | 8 | Ring id |
| ev_vm | input | 8 | VM id |
| ev_pasid | input | 16 | PASID |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts request |
| mem_addr | output | 40 | Byte address of the word |
| mem_wdata | output | 32 | Word to write |
| irq | output | 1 | Interrupt pulse |
| pending | output | 1 | Unread entries present |
| busy | output | 1 | Vector or writeback in progress |

## Verification
The bench builds the block with MAX_LOG2W = 6, so the largest ring is 256 bytes. A size field of 12 is clamped by that limit, and 16 vectors are enough to go once round a clamped ring. A size of 3 gives a two-vector ring, where both the wrap and the overflow collision follow within three events. Random backpressure on mem_ready exercises the hold rule for the request.

// File: rtl/ivring_writer.sv
`timescale 1ns/1ps
module ivring_writer #(
  parameter int MAX_LOG2W = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_valid,
  output logic        ev_ready,
  input  logic [7:0]  ev_src,
  input  logic [27:0] ev_data,
  input  logic [7:0]  ev_ring,
  input  logic [7:0]  ev_vm,
  input  logic [15:0] ev_pasid,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic [39:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        irq,
  output logic        pending,
  output logic        busy
);
  localparam int PW = MAX_LOG2W + 2;

  typedef enum logic [1:0] {IDLE, VEC, WB} st_t;

  logic          ring_en, irq_en, ovf_en, wb_en, rearm_en;
  logic [4:0]    size_q, sz;
  logic [31:0]   base_q, wblo_q;
  logic [7:0]    wbhi_q;
  logic [PW-1:0] wptr_q, rptr_q, mask, next_wptr, wr_ptr_val;
  logic          ovf_q, irq_q;
  st_t           st;
  logic [1:0]    widx;
  logic [7:0]    src_q;
  logic [27:0]   data_q;
  logic [31:0]   w2_q, wval;
  logic          accept, beat, last_vec, done, rearm_hit;

  assign sz         = (size_q > 5'(MAX_LOG2W)) ? 5'(MAX_LOG2W) : size_q;
  assign mask       = {PW{1'b1}} >> (PW - 2 - int'(sz));
  assign next_wptr  = (wptr_q + PW'(16)) & mask;
  assign wr_ptr_val = reg_wdata[PW-1:0] & mask & ~PW'(15);
  assign wval       = 32'(wptr_q) | 32'(ovf_q);

  assign ev_ready  = ring_en && (st == IDLE);
  assign accept    = ev_valid && ev_ready;
  assign mem_valid = (st != IDLE);
  assign beat      = mem_valid && mem_ready;
  assign last_vec  = beat && (st == VEC) && (widx == 2'd3);
  assign done      = (last_vec && !wb_en) || (beat && st == WB);
  assign rearm_hit = reg_wr && (reg_addr == 3'd2) && rearm_en && irq_en &&
                     (wr_ptr_val != wptr_q);

  assign busy    = (st != IDLE);
  assign pending = ring_en && (rptr_q != wptr_q);
  assign irq     = irq_q;

  assign mem_addr = (st == WB) ? {wbhi_q, wblo_q}
                  : {base_q, 8'h00} + 40'(wptr_q) + 40'({widx, 2'b00});

  always_comb begin
    if (st == WB) mem_wdata = wval;
    else begin
      case (widx)
        2'd0:    mem_wdata = {24'h0, src_q};
        2'd1:    mem_wdata = {4'h0, data_q};
        2'd2:    mem_wdata = w2_q;
        default: mem_wdata = 32'h0;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {19'h0, size_q, 3'b000, rearm_en, wb_en, ovf_en, irq_en, ring_en};
      3'd1:    reg_rdata = base_q;
      3'd2:    reg_rdata = 32'(rptr_q);
      3'd3:    reg_rdata = wval;
      3'd4:    reg_rdata = wblo_q;
      3'd5:    reg_rdata = {24'h0, wbhi_q};
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ring_en, irq_en, ovf_en, wb_en, rearm_en} <= '0;
      size_q <= '0;
      base_q <= '0;
      wblo_q <= '0;
      wbhi_q <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
      st     <= IDLE;
      widx   <= '0;
      src_q  <= '0;
      data_q <= '0;
      w2_q   <= '0;
    end else begin
      irq_q <= (done && irq_en) || rearm_hit;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: begin
            {rearm_en, wb_en, ovf_en, irq_en, ring_en} <= reg_wdata[4:0];
            size_q <= reg_wdata[12:8];
            if (reg_wdata[5]) ovf_q <= 1'b0;
          end
          3'd1: base_q <= reg_wdata;
          3'd2: rptr_q <= wr_ptr_val;
          3'd3: if (!ring_en) wptr_q <= wr_ptr_val;
          3'd4: wblo_q <= reg_wdata;
          3'd5: wbhi_q <= reg_wdata[7:0];
          default: ;
        endcase
      end
      case (st)
        IDLE: if (accept) begin
          src_q  <= ev_src;
          data_q <= ev_data;
          w2_q   <= {ev_pasid, ev_vm, ev_ring};
          widx   <= 2'd0;
          st     <= VEC;
        end
        VEC: if (beat) begin
          widx <= widx + 2'd1;
          if (widx == 2'd3) begin
            wptr_q <= next_wptr;
            if (ovf_en && next_wptr == rptr_q) ovf_q <= 1'b1;
            st <= wb_en ? WB : IDLE;
          end
        end
        WB: if (beat) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ivring_writer_chk.sv
`timescale 1ns/1ps
module ivring_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_valid,
  input logic        ev_ready,
  input logic        busy,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [39:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        irq,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_rdata
);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));

  assert_busy_after_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready) |=> busy);

  assert_no_take_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready |-> !busy);

  assert_wptr_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd3) |-> (reg_rdata[3:1] == 3'b000));

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(mem_valid && mem_ready) || $past(reg_wr)));
endmodule

bind ivring_writer ivring_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready), .busy(busy),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .irq(irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata)
);

// File: tb/ivring_writer_test.sv
`timescale 1ns/1ps
module ivring_writer_test;
  localparam int MAXL = 6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ev_valid = 1'b0, ev_ready;
  logic [7:0]  ev_src = '0, ev_ring = '0, ev_vm = '0;
  logic [27:0] ev_data = '0;
  logic [15:0] ev_pasid = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_valid, mem_ready = 1'b1;
  logic [39:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        irq, pending, busy;

  ivring_writer #(.MAX_LOG2W(MAXL)) uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_src(ev_src), .ev_data(ev_data), .ev_ring(ev_ring), .ev_vm(ev_vm),
    .ev_pasid(ev_pasid), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .irq(irq), .pending(pending), .busy(busy));

  always #5 clk = ~clk;

  int total = 0, bad = 0, cap_n = 0, irq_cnt = 0;
  logic [39:0] cap_a [256];
  logic [31:0] cap_d [256];
  logic        bp = 1'b0;
  logic [7:0]  lfsr = 8'h5B;
  bit          finished = 0;

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      cap_a[cap_n % 256] <= mem_addr;
      cap_d[cap_n % 256] <= mem_wdata;
      cap_n <= cap_n + 1;
    end
    if (rst_n && irq) irq_cnt <= irq_cnt + 1;
  end

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready = bp ? (lfsr[0] & lfsr[2]) : 1'b1;
  end

  // bench model of the programmed state
  bit m_ring, m_irq_en, m_ovf_en, m_wb, m_rearm, m_ovf;
  int m_size, m_wptr, m_rptr, m_irq;
  logic [31:0] m_base, m_wblo;
  logic [7:0]  m_wbhi;

  function automatic int mk();
    int s;
    s = (m_size > MAXL) ? MAXL : m_size;
    return (1 << (s + 2)) - 1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    int nv;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    nv = int'(d) & mk() & ~15;
    case (a)
      3'd0: begin
        {m_rearm, m_wb, m_ovf_en, m_irq_en, m_ring} = d[4:0];
        m_size = int'(d[12:8]);
        if (d[5]) m_ovf = 0;
      end
      3'd1: m_base = d;
      3'd2: begin
        if (m_rearm && m_irq_en && nv != m_wptr) m_irq++;
        m_rptr = nv;
      end
      3'd3: if (!m_ring) m_wptr = nv;
      3'd4: m_wblo = d;
      3'd5: m_wbhi = d[7:0];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic chk_irq(input string tag);
    @(negedge clk);
    @(negedge clk);
    chk(tag, 64'(irq_cnt), 64'(m_irq));
  endtask

  task automatic push(input logic [7:0] s, input logic [27:0] d, input logic [7:0] r,
                      input logic [7:0] v, input logic [15:0] p);
    int st, nx, n_exp;
    logic [39:0] b;
    logic [31:0] w [4];
    logic [31:0] val;
    st = cap_n;
    b = {m_base, 8'h00} + 40'(m_wptr);
    w[0] = {24'h0, s}; w[1] = {4'h0, d}; w[2] = {p, v, r}; w[3] = 32'h0;
    @(negedge clk);
    ev_valid = 1'b1; ev_src = s; ev_data = d; ev_ring = r; ev_vm = v; ev_pasid = p;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R11 busy after accept", 64'(busy), 64'd1);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R11 busy low when done", 64'(busy), 64'd0);
    nx = (m_wptr + 16) & mk();
    if (m_ovf_en && nx == m_rptr) m_ovf = 1;
    m_wptr = nx;
    if (m_irq_en) m_irq++;
    n_exp = m_wb ? 5 : 4;
    chk("R2/R7 write count", 64'(cap_n - st), 64'(n_exp));
    for (int i = 0; i < 4; i++) begin
      chk("R2 word addr", 64'(cap_a[(st + i) % 256]), 64'(b + 40'(4 * i)));
      chk("R2 word data", 64'(cap_d[(st + i) % 256]), 64'(w[i]));
    end
    if (m_wb) begin
      chk("R7 writeback addr", 64'(cap_a[(st + 4) % 256]), 64'({m_wbhi, m_wblo}));
      chk("R7 writeback data", 64'(cap_d[(st + 4) % 256]), 64'(m_wptr | int'(m_ovf)));
    end
    rd(3'd3, val);
    chk("R3/R5 wptr value", 64'(val), 64'(m_wptr | int'(m_ovf)));
    chk("R9 irq count", 64'(irq_cnt), 64'(m_irq));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 register reset", 64'(v), 64'd0);
    end
    chk("R1 ev_ready", 64'(ev_ready), 64'd0);
    chk("R1 mem_valid", 64'(mem_valid), 64'd0);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 pending", 64'(pending), 64'd0);
    chk("R1 irq", 64'(irq_cnt), 64'd0);
  endtask

  task automatic t_basic();
    wr(3'd1, 32'h00ABCD01);
    wr(3'd0, 32'h00000607);
    push(8'hA5, 28'hABCDEF1, 8'h3C, 8'h7E, 16'hBEEF);
    chk("R4 pending with entry", 64'(pending), 64'd1);
    wr(3'd2, 32'h10);
    chk("R4 idle after drain", 64'(pending), 64'd0);
    chk_irq("R10 no rearm when off");
  endtask

  task automatic t_wrap();
    bp = 1'b1;
    wr(3'd0, 32'h300);
    wr(3'd3, 0);
    wr(3'd2, 0);
    wr(3'd0, 32'h307);
    push(8'h01, 28'h1111111, 8'h02, 8'h03, 16'h0004);
    wr(3'd2, 32'h10);
    push(8'h11, 28'h2222222, 8'h12, 8'h13, 16'h0014);
    chk("R3 wrap to zero", 64'(m_wptr), 64'd0);
    push(8'h21, 28'h3333333, 8'h22, 8'h23, 16'h0024);
    chk("R5 overflow flagged", 64'(m_ovf), 64'd1);
    bp = 1'b0;
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(3'd0, 32'h327);
    rd(3'd3, v);
    chk("R6 flag cleared", 64'(v), 64'h10);
    rd(3'd0, v);
    chk("R6 clear bit reads 0", 64'(v), 64'h307);
  endtask

  task automatic t_noovf();
    wr(3'd0, 32'h303);
    push(8'h31, 28'h0000001, 8'h00, 8'h00, 16'h0000);
    push(8'h32, 28'h0000002, 8'h00, 8'h00, 16'h0000);
    chk("R5 no flag when disabled", 64'(m_ovf), 64'd0);
  endtask

  task automatic t_wb();
    wr(3'd4, 32'h00002040);
    wr(3'd5, 32'h0000005A);
    wr(3'd0, 32'h30F);
    bp = 1'b1;
    push(8'h41, 28'h4444444, 8'h42, 8'h43, 16'h4444);
    push(8'h51, 28'h5555555, 8'h52, 8'h53, 16'h5555);
    chk("R7 mirrored flag", 64'(m_ovf), 64'd1);
    bp = 1'b0;
  endtask

  task automatic t_gate();
    logic [31:0] v;
    int n0;
    wr(3'd3, 32'h40);
    rd(3'd3, v);
    chk("R8 wptr write ignored when on", 64'(v), 64'(m_wptr | int'(m_ovf)));
    wr(3'd0, 32'h300);
    n0 = cap_n;
    @(negedge clk);
    ev_valid = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 ev_ready low when off", 64'(ev_ready), 64'd0);
    ev_valid = 1'b0;
    @(negedge clk);
    chk("R8 no write when off", 64'(cap_n), 64'(n0));
    wr(3'd3, 32'h10);
    rd(3'd3, v);
    chk("R8 wptr write taken when off", 64'(v), 64'(m_wptr | int'(m_ovf)));
    wr(3'd0, 32'h320);
    wr(3'd2, 32'h10);
  endtask

  task automatic t_noirq();
    wr(3'd0, 32'h305);
    push(8'h61, 28'h6666666, 8'h62, 8'h63, 16'h6666);
    chk_irq("R9 no pulse when disabled");
  endtask

  task automatic t_rearm();
    wr(3'd0, 32'h313);
    wr(3'd2, 32'((m_wptr ^ 16) & mk()));
    chk_irq("R10 rearm pulse");
    wr(3'd2, 32'(m_wptr));
    chk_irq("R10 no pulse when equal");
    wr(3'd0, 32'h303);
    wr(3'd2, 32'((m_wptr ^ 16) & mk()));
    chk_irq("R10 no pulse when rearm off");
  endtask

  task automatic t_clamp();
    logic [31:0] v;
    wr(3'd0, 32'h0);
    wr(3'd3, 0);
    wr(3'd2, 0);
    wr(3'd0, 32'h0C03);
    rd(3'd0, v);
    chk("R3 size field readback", 64'(v), 64'h0C03);
    for (int i = 0; i < 16; i++)
      push(8'(i), 28'(i * 3), 8'(i), 8'(i + 1), 16'(i * 7));
    chk("R3 clamped wrap", 64'(m_wptr), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_clear();
    t_noovf();
    t_wb();
    t_gate();
    t_noirq();
    t_rearm();
    t_clamp();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule